// File: doc/BRIEF.md
# Interlocked Bus Peripheral Register Slave

This block is the slave end of an asynchronous, fully interlocked backplane bus. It presents a small bank of 16-bit peripheral registers at a fixed window near the top of an 18-bit address space, the part of that space set aside for device registers. A master places an address, a 2-bit cycle code and, for writes, data on the bus, then raises its strobe. The slave takes that strobe through a two-flop synchroniser and decodes the address. It carries out the access and raises its acknowledge. It holds the acknowledge until the master lets the strobe go, and then drops it. No response is tied to a fixed time, so masters of any speed can be mixed.

Four cycle types are served: word read, a paused read that opens a read-modify-write, word write and byte write. A paused read locks the slave onto the register it read. Until a word or byte write to that same register arrives, every other access is left waiting without an acknowledge. Addresses outside the window are never acknowledged, so the master detects them through its own timeout.

Top module: `bus_slave_regs`

## Requirements
- R1: After reset the acknowledge output is low, the read data output is zero, every register holds zero and the slave is not locked.
- R2: The window is BASE to BASE+2*NREG-1 (default 0x3FF80 to 0x3FF8F). Register i sits at BASE+2*i. Any access outside the window gets no acknowledge and changes no register.
- R3: Cycle code 00 is a word read: the addressed register appears on the read data output, which stays steady while the acknowledge is high.
- R4: Cycle code 10 is a word write: all 16 bits of the addressed register take the write data.
- R5: Cycle code 11 is a byte write. With address bit 0 low, only bits 7:0 take write data bits 7:0. With it high, only bits 15:8 take write data bits 15:8.
- R6: Cycle code 01 is a paused read. It returns data like a word read and locks the slave onto that register. While locked, any read or paused read, and any write to another register, gets no acknowledge and changes nothing. A word or byte write to the locked register is acknowledged, completes the operation and clears the lock.
- R7: The acknowledge rises no earlier than the third clock edge after the strobe rises. It stays high while the strobe stays high, and it falls only after the strobe has fallen. Each strobe performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock, used only for the internal logic |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 18 | Address from the master |
| bus_ctl | input | 2 | Cycle code, {C1,C0} |
| bus_wdata | input | 16 | Write data from the master |
| bus_msync | input | 1 | Master strobe, asynchronous |
| bus_rdata | output | 16 | Read data to the master |
| bus_ssync | output | 1 | Slave acknowledge |

## Verification
On every cycle, the assertions check the order of the handshake. The acknowledge rises only after the strobe has been high for two sampled edges, it stays up while the strobe does, and it falls only after the strobe has dropped. They also check that every acknowledge is for an address inside the window, that read data holds while acknowledged, and that a locked slave acknowledges only writes. Register contents after byte and word writes, the held-off accesses during a read-modify-write, and the silence on a miss only show up in the bench's scenarios, which read the registers back through the bus.

// File: rtl/bus_slave_pkg.sv
// Shared types for the interlocked bus slave.
// Assumes the cycle code is the 2-bit {C1,C0} field driven by the master.
package bus_slave_pkg;

    typedef enum logic [1:0] {
        CYC_READ   = 2'b00,
        CYC_RDLOCK = 2'b01,
        CYC_WRITE  = 2'b10,
        CYC_WRBYTE = 2'b11
    } cyc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } hs_state_t;

endpackage

// File: rtl/bs_strobe_sync.sv
// Multi-flop synchroniser for the asynchronous master strobe.
// Assumes STAGES >= 2; the output lags the input by STAGES clock edges.
module bs_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw strobe through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/bs_addr_decode.sv
// Address window decoder: flags a hit, and splits out the register index and byte lane.
// Assumes NREG and NBYTES are powers of two and BASE is aligned to the window size.
module bs_addr_decode #(
    parameter int                  ADDR_W = 18,
    parameter int                  NREG   = 8,
    parameter int                  NBYTES = 2,
    parameter logic [ADDR_W-1:0]   BASE   = 18'h3FF80,
    localparam int                 IDX_W  = $clog2(NREG),
    localparam int                 LANE_W = $clog2(NBYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane
);

    localparam int WIN_LSB = IDX_W + LANE_W;

    // Compare the upper bits with the base and slice out the index and lane.
    always_comb begin
        hit  = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        idx  = addr[WIN_LSB-1:LANE_W];
        lane = addr[LANE_W-1:0];
    end

endmodule

// File: rtl/bs_reg_bank.sv
// Peripheral register storage with per-byte write enables and a combinational read port.
// Assumes at most one write per clock.
module bs_reg_bank #(
    parameter int  DATA_W = 16,
    parameter int  NREG   = 8,
    localparam int NBYTES = DATA_W / 8,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NBYTES-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] merged;

    // Build the written word lane by lane from old contents and new data.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[b*8 +: 8] = wr_mask[b] ? wr_data[b*8 +: 8] : regs_q[wr_idx][b*8 +: 8];
    end

    // Clear on reset, otherwise store the merged word into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_idx] <= merged;
        end
    end

    assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/bus_slave_regs.sv
// Slave register interface for an asynchronous interlocked bus.
// The strobe is synchronised, the access is done once per strobe, and the acknowledge
// is held until the strobe falls. A paused read locks the slave to one register
// until a write to it arrives. Assumes the master keeps address, code and data
// stable from before its strobe rises until it sees the acknowledge.
module bus_slave_regs
    import bus_slave_pkg::*;
#(
    parameter int                ADDR_W = 18,
    parameter int                DATA_W = 16,
    parameter int                NREG   = 8,
    parameter logic [ADDR_W-1:0] BASE   = 18'h3FF80,
    parameter int                SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_ctl,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_msync,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ssync
);

    localparam int NBYTES = DATA_W / 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int LANE_W = $clog2(NBYTES);

    logic              strb_s;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] lane;
    logic [DATA_W-1:0] rd_word;
    hs_state_t         state_q;
    logic              lock_q;
    logic [IDX_W-1:0]  lock_idx_q;
    logic [DATA_W-1:0] rdata_q;
    cyc_t              cyc;
    logic              is_wr;
    logic              lock_ok;
    logic              accept;
    logic [NBYTES-1:0] wmask;

    bs_strobe_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_msync),
        .sync_out (strb_s)
    );

    bs_addr_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .NBYTES(NBYTES), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx),
        .lane (lane)
    );

    // Decide whether the pending strobe may be served now, and with which byte mask.
    always_comb begin
        cyc     = cyc_t'(bus_ctl);
        is_wr   = (cyc == CYC_WRITE) || (cyc == CYC_WRBYTE);
        lock_ok = !lock_q || (is_wr && (idx == lock_idx_q));
        accept  = (state_q == ST_IDLE) && strb_s && hit && lock_ok;
        wmask   = (cyc == CYC_WRBYTE) ? NBYTES'(1) << lane : '1;
    end

    bs_reg_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && is_wr),
        .wr_idx  (idx),
        .wr_mask (wmask),
        .wr_data (bus_wdata),
        .rd_idx  (idx),
        .rd_data (rd_word)
    );

    // Handshake sequencing, read data capture and read-modify-write lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
            rdata_q    <= '0;
        end else if (accept) begin
            state_q <= ST_ACK;
            if (!is_wr) rdata_q <= rd_word;
            if (cyc == CYC_RDLOCK) begin
                lock_q     <= 1'b1;
                lock_idx_q <= idx;
            end else if (is_wr) begin
                lock_q <= 1'b0;
            end
        end else if (state_q == ST_ACK && !strb_s) begin
            state_q <= ST_IDLE;
        end
    end

    assign bus_ssync = (state_q == ST_ACK);
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/bus_slave_regs_chk.sv
// Protocol checker for bus_slave_regs, attached with bind.
// Assumes the master follows the interlock (signals stable until acknowledged).
module bus_slave_regs_chk #(
    parameter int                ADDR_W = 18,
    parameter int                DATA_W = 16,
    parameter int                NREG   = 8,
    parameter logic [ADDR_W-1:0] BASE   = 18'h3FF80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_ctl,
    input logic              bus_msync,
    input logic              bus_ssync,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lock_q
);

    localparam logic [ADDR_W-1:0] LAST = BASE + ADDR_W'(2 * NREG - 1);

    p_ack_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssync) |-> ($past(bus_msync, 1) && $past(bus_msync, 2)));

    p_ack_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ssync && bus_msync) |=> bus_ssync);

    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ssync) |-> !$past(bus_msync));

    p_ack_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssync) |-> ($past(bus_addr) >= BASE && $past(bus_addr) <= LAST));

    p_rdata_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ssync && $past(bus_ssync)) |-> $stable(bus_rdata));

    p_lock_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ssync) && $past(lock_q)) |-> $past(bus_ctl[1]));

endmodule

bind bus_slave_regs bus_slave_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .BASE(BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_ctl   (bus_ctl),
    .bus_msync (bus_msync),
    .bus_ssync (bus_ssync),
    .bus_rdata (bus_rdata),
    .lock_q    (lock_q)
);

// File: tb/test_bus_slave_regs.sv
// Directed bench for bus_slave_regs: one task per scenario, each checking its own results.
module test_bus_slave_regs;

    localparam logic [17:0] BASE = 18'h3FF80;
    localparam int          NREG = 8;
    localparam int          TMO  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [1:0]  bus_ctl = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_msync = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_ssync;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    bus_slave_regs i_bus_slave_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_ctl   (bus_ctl),
        .bus_wdata (bus_wdata),
        .bus_msync (bus_msync),
        .bus_rdata (bus_rdata),
        .bus_ssync (bus_ssync)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; returns whether it was acknowledged and the read data.
    task automatic bus_cycle(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d,
                             output logic acked, output logic [15:0] rd, output int lat);
        @(negedge clk);
        bus_addr = a; bus_ctl = c; bus_wdata = d;
        @(negedge clk);
        bus_msync = 1'b1;
        acked = 1'b0; lat = 0; rd = '0;
        for (int n = 1; n <= TMO; n++) begin
            @(negedge clk);
            if (bus_ssync) begin acked = 1'b1; lat = n; break; end
        end
        rd = bus_rdata;
        bus_msync = 1'b0;
        if (acked) begin
            for (int n = 0; n < TMO && bus_ssync; n++) @(negedge clk);
            chk("R7 ack falls after strobe", 32'(bus_ssync), 0);
        end
        @(negedge clk);
    endtask

    task automatic rd_reg(input int i, input string req, input logic [15:0] exp);
        logic ak; logic [15:0] rd; int lat;
        bus_cycle(BASE + 18'(2 * i), 2'b00, 16'h0, ak, rd, lat);
        chk({req, " read ack"}, 32'(ak), 1);
        chk({req, " read data"}, 32'(rd), 32'(exp));
    endtask

    task automatic wr_reg(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d,
                          input string req, input logic exp_ack);
        logic ak; logic [15:0] rd; int lat;
        bus_cycle(a, c, d, ak, rd, lat);
        chk({req, " write ack"}, 32'(ak), 32'(exp_ack));
    endtask

    task automatic t_reset();
        chk("R1 ssync after reset", 32'(bus_ssync), 0);
        chk("R1 rdata after reset", 32'(bus_rdata), 0);
        for (int i = 0; i < NREG; i++) rd_reg(i, "R1", 16'h0);
    endtask

    task automatic t_word_rw();
        for (int i = 0; i < NREG; i++)
            wr_reg(BASE + 18'(2 * i), 2'b10, 16'hA500 ^ 16'(i * 16'h1111), "R4", 1'b1);
        for (int i = 0; i < NREG; i++) rd_reg(i, "R3 R4", 16'hA500 ^ 16'(i * 16'h1111));
        wr_reg(BASE + 18'd6, 2'b10, 16'hFFFF, "R4", 1'b1);
        rd_reg(3, "R4 all ones", 16'hFFFF);
    endtask

    task automatic t_byte();
        wr_reg(BASE + 18'd2, 2'b10, 16'h1234, "R5 setup", 1'b1);
        wr_reg(BASE + 18'd2, 2'b11, 16'hEEAB, "R5 low lane", 1'b1);
        rd_reg(1, "R5 low lane", 16'h12AB);
        wr_reg(BASE + 18'd3, 2'b11, 16'hCDEE, "R5 high lane", 1'b1);
        rd_reg(1, "R5 high lane", 16'hCDAB);
    endtask

    task automatic t_miss();
        logic ak; logic [15:0] rd; int lat;
        wr_reg(BASE - 18'd2, 2'b10, 16'hDEAD, "R2 below window", 1'b0);
        wr_reg(BASE + 18'(2 * NREG), 2'b10, 16'hBEEF, "R2 above window", 1'b0);
        bus_cycle(18'h00010, 2'b00, 16'h0, ak, rd, lat);
        chk("R2 low memory read ack", 32'(ak), 0);
        rd_reg(0, "R2 unchanged", 16'hA500);
        rd_reg(NREG - 1, "R2 unchanged", 16'hA500 ^ 16'(7 * 16'h1111));
    endtask

    task automatic t_rmw();
        logic ak; logic [15:0] rd; int lat;
        wr_reg(BASE + 18'd4, 2'b10, 16'h5A5A, "R6 setup", 1'b1);
        bus_cycle(BASE + 18'd4, 2'b01, 16'h0, ak, rd, lat);
        chk("R6 paused read ack", 32'(ak), 1);
        chk("R6 paused read data", 32'(rd), 32'h5A5A);
        bus_cycle(BASE + 18'd6, 2'b00, 16'h0, ak, rd, lat);
        chk("R6 read held off", 32'(ak), 0);
        bus_cycle(BASE + 18'd4, 2'b01, 16'h0, ak, rd, lat);
        chk("R6 paused read held off", 32'(ak), 0);
        wr_reg(BASE + 18'd10, 2'b10, 16'h0BAD, "R6 other write held off", 1'b0);
        wr_reg(BASE + 18'd5, 2'b11, 16'h7700, "R6 completing byte write", 1'b1);
        rd_reg(2, "R6 merged", 16'h775A);
        rd_reg(5, "R6 other reg unchanged", 16'hA500 ^ 16'(5 * 16'h1111));
        bus_cycle(BASE + 18'd4, 2'b01, 16'h0, ak, rd, lat);
        chk("R6 second lock ack", 32'(ak), 1);
        wr_reg(BASE + 18'd4, 2'b10, 16'h1357, "R6 completing word write", 1'b1);
        rd_reg(2, "R6 after word completion", 16'h1357);
    endtask

    task automatic t_handshake();
        logic ak; logic [15:0] rd; int lat;
        bus_cycle(BASE, 2'b00, 16'h0, ak, rd, lat);
        chk("R7 latency at least three edges", 32'(lat >= 3), 1);
        @(negedge clk);
        bus_addr = BASE + 18'd8; bus_ctl = 2'b11; bus_wdata = 16'h00C3;
        @(negedge clk);
        bus_msync = 1'b1;
        repeat (20) @(negedge clk);
        chk("R7 ack held with strobe", 32'(bus_ssync), 1);
        bus_msync = 1'b0;
        @(negedge clk);
        chk("R7 ack not dropped at once", 32'(bus_ssync), 1);
        repeat (4) @(negedge clk);
        chk("R7 ack released", 32'(bus_ssync), 0);
        rd_reg(4, "R7 single access", (16'hA500 ^ 16'(4 * 16'h1111)) & 16'hFF00 | 16'h00C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_rw();
        t_byte();
        t_miss();
        t_rmw();
        t_handshake();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule